// File: doc/BRIEF.md
# Partitioned Bit-Serial FIR Filter with Serial Adder Tree

The block computes a long FIR filter on a bit-serial sample stream by splitting the taps into `N_SUB` equal groups of `TAPS` taps. Each group has its own delay segment and a small distributed-arithmetic core. The core addresses a `2**TAPS`-entry table of coefficient sums with one bit from each tap of its group. The delay segments form one chain, so group `i` sees the `TAPS` consecutive samples that start `i*TAPS` samples back in history.

Each core produces its partial result one bit per clock, least significant bit first. The partial results are merged by a tree of single-bit serial adders, each a full adder with a carry flip-flop. The tree has depth `ceil(log2 N_SUB)`, and each level adds one bit of width and one cycle of delay. The output therefore carries `DATA_W + ceil(log2 N_SUB)` bits per result, and a new sample is accepted once every frame of that many cycles. The coefficient tables grow with `2**TAPS` per group rather than with `2**(N_SUB*TAPS)`, so the area rises roughly in line with the number of taps.

Top module: `dist_fir_tree`

## Requirements
- R1: An active-low asynchronous reset clears the delay segments, accumulators, carries and output register. `y_o` is 0 during reset and stays 0 while only zero samples are fed.
- R2: `frame_i` is high for one cycle, in the cycle that carries bit 0 of a sample. `x_i` carries a `DATA_W`-bit two's-complement sample LSB first over the `DATA_W` cycles that start at the strobe. Strobes come exactly FRAME = `DATA_W + ceil(log2 N_SUB)` cycles apart.
- R3: Each result on `y_o` is the low FRAME bits, two's complement and LSB first, of the sum over g of c[g]*x[n-g], for g = 0 .. `N_SUB*TAPS-1`. Samples before reset count as 0.
- R4: Bit j of result n is on `y_o` exactly `ceil(log2 N_SUB)+1` cycles after the cycle that carries input bit j of sample n. In particular, bit 0 appears that many cycles after its strobe.
- R5: Coefficient c[g] is `COEFS[g*COEF_W +: COEF_W]`, signed. Group i handles g = i*TAPS .. i*TAPS+TAPS-1. The oldest sample of a group feeds the next group, so a unit impulse reproduces c[0], c[1], ... in order on successive results.
- R6: The input MSB has weight -2^(DATA_W-1). The extreme samples -2^(DATA_W-1) and 2^(DATA_W-1)-1 give exact results.
- R7: `x_i` is ignored in the frame cycles from `DATA_W` to FRAME-1. The delay segments hold their contents during those cycles.
- R8: Every serial adder clears its carry when bit 0 of a new result reaches it, so no carry passes from one result into the next.
- R9: When a tree level has an odd number of operands, the unpaired operand passes through a one-cycle register. This keeps all operands of the next level bit-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Strobe marking bit 0 of each input sample |
| x_i | input | 1 | Serial sample input, LSB first |
| y_o | output | 1 | Serial filter result, LSB first |

## Verification
The assertions take for granted that the frame strobe, once started, recurs every FRAME cycles and is never missing or early. The checks on tap hold, carry clearing and pass-through alignment all count frame positions from that strobe. The stimulus keeps the strobe on a fixed FRAME cadence from the first sample to the end of the run, including the zero samples that flush the tree. It also drives arbitrary bits on `x_i` in the spare cycles, so that only the data cycles carry meaning.

// File: rtl/fir_tree_pkg.sv
package fir_tree_pkg;

  // operands present at a given tree level
  function automatic int lvl_cnt(input int n_sub, input int lvl);
    return (n_sub + (1 << lvl) - 1) >> lvl;
  endfunction

  // base index of a tree level in the flat node vector
  function automatic int lvl_off(input int n_sub, input int lvl);
    int s;
    s = 0;
    for (int i = 0; i < lvl; i++) s += lvl_cnt(n_sub, i);
    return s;
  endfunction

endpackage

// File: rtl/tap_seg.sv
module tap_seg #(
  parameter int  DATA_W = 8,
  parameter int  TAPS   = 3,
  parameter bit  FIRST  = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            din_i,
  output logic [TAPS-1:0] taps_o
);
  // first segment takes its newest tap straight from the input pin
  localparam int NREG = FIRST ? TAPS - 1 : TAPS;

  logic [DATA_W-1:0] sr_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) sr_q[r] <= '0;
    end else if (shift_i) begin
      sr_q[0] <= {din_i, sr_q[0][DATA_W-1:1]};
      for (int r = 1; r < NREG; r++) sr_q[r] <= {sr_q[r-1][0], sr_q[r][DATA_W-1:1]};
    end
  end

  if (FIRST) begin : g_first
    always_comb begin
      taps_o[0] = din_i;
      for (int t = 1; t < TAPS; t++) taps_o[t] = sr_q[t-1][0];
    end
  end else begin : g_rest
    always_comb begin
      for (int t = 0; t < TAPS; t++) taps_o[t] = sr_q[t][0];
    end
  end

endmodule

// File: rtl/da_core.sv
module da_core #(
  parameter int                    TAPS   = 3,
  parameter int                    COEF_W = 6,
  parameter logic [TAPS*COEF_W-1:0] COEF  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            act_i,
  input  logic            neg_i,
  input  logic [TAPS-1:0] addr_i,
  output logic            bit_o
);
  localparam int NLUT  = 2 ** TAPS;
  localparam int F_W   = COEF_W + $clog2(TAPS) + 1;
  localparam int ACC_W = F_W + 1;

  function automatic logic signed [F_W-1:0] entry(input int e);
    logic signed [F_W-1:0] s;
    s = '0;
    for (int t = 0; t < TAPS; t++)
      if (e[t]) s = s + F_W'(signed'(COEF[t*COEF_W +: COEF_W]));
    return s;
  endfunction

  logic signed [F_W-1:0]   lut [NLUT];
  logic signed [F_W-1:0]   f;
  logic signed [ACC_W-1:0] f_x, term, base, sum, acc_q;
  logic                    bit_q;

  for (genvar e = 0; e < NLUT; e++) begin : g_lut
    assign lut[e] = entry(e);
  end

  always_comb begin
    f    = lut[addr_i];
    f_x  = {{(ACC_W-F_W){f[F_W-1]}}, f};
    term = act_i ? (neg_i ? -f_x : f_x) : '0;
    base = clr_i ? '0 : acc_q;
    sum  = base + term;
  end

  // outside the data bits the accumulator keeps shifting: sign extension
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= sum >>> 1;
      bit_q <= sum[0];
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/ser_add.sv
module ser_add (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  output logic s_o
);
  logic c_q, s_q, cin;

  assign cin = clr_i ? 1'b0 : c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      s_q <= a_i ^ b_i ^ cin;
      c_q <= (a_i & b_i) | (a_i & cin) | (b_i & cin);
    end
  end

  assign s_o = s_q;

endmodule

// File: rtl/dist_fir_tree.sv
module dist_fir_tree #(
  parameter int                           N_SUB  = 3,
  parameter int                           TAPS   = 3,
  parameter int                           DATA_W = 8,
  parameter int                           COEF_W = 6,
  parameter logic [N_SUB*TAPS*COEF_W-1:0] COEFS  = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic x_i,
  output logic y_o
);
  import fir_tree_pkg::*;

  localparam int LVL   = $clog2(N_SUB);
  localparam int FRAME = DATA_W + LVL;
  localparam int POS_W = $clog2(FRAME);
  localparam int NTAP  = N_SUB * TAPS;
  localparam int NODES = lvl_off(N_SUB, LVL + 1);

  logic [POS_W-1:0] pos_q, pos;
  logic             shift, sgn, clr0;
  logic [NTAP-1:0]  tap_bits;
  logic [NODES-1:0] nb;

  // frame position, resynchronised by every strobe
  assign pos = frame_i ? '0 : pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= (int'(pos) == FRAME - 1) ? '0 : pos + 1'b1;
  end

  assign shift = int'(pos) < DATA_W;
  assign sgn   = int'(pos) == DATA_W - 1;
  assign clr0  = int'(pos) == 0;

  for (genvar i = 0; i < N_SUB; i++) begin : g_sub
    logic din;
    if (i == 0) begin : g_head
      assign din = x_i;
    end else begin : g_link
      assign din = tap_bits[i*TAPS-1];
    end

    tap_seg #(
      .DATA_W (DATA_W),
      .TAPS   (TAPS),
      .FIRST  (i == 0)
    ) u_seg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (shift),
      .din_i   (din),
      .taps_o  (tap_bits[i*TAPS +: TAPS])
    );

    da_core #(
      .TAPS   (TAPS),
      .COEF_W (COEF_W),
      .COEF   (COEFS[i*TAPS*COEF_W +: TAPS*COEF_W])
    ) u_da (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr0),
      .act_i  (shift),
      .neg_i  (sgn),
      .addr_i (tap_bits[i*TAPS +: TAPS]),
      .bit_o  (nb[i])
    );
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    for (genvar m = 0; m < lvl_cnt(N_SUB, l + 1); m++) begin : g_node
      localparam int SRC = lvl_off(N_SUB, l) + 2 * m;
      localparam int DST = lvl_off(N_SUB, l + 1) + m;
      if (2 * m + 1 < lvl_cnt(N_SUB, l)) begin : g_add
        ser_add u_add (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .clr_i  (int'(pos) == (l + 1) % FRAME),
          .a_i    (nb[SRC]),
          .b_i    (nb[SRC+1]),
          .s_o    (nb[DST])
        );
      end else begin : g_pass
        // unpaired operand: match the adder's one-cycle delay
        logic pass_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pass_q <= 1'b0;
          else         pass_q <= nb[SRC];
        end
        assign nb[DST] = pass_q;
      end
    end
  end

  assign y_o = nb[NODES-1];

endmodule

// File: rtl/dist_fir_tree_chk.sv
module dist_fir_tree_chk #(
  parameter int N_SUB  = 3,
  parameter int TAPS   = 3,
  parameter int DATA_W = 8
) (
  input logic                                        clk_i,
  input logic                                        rst_ni,
  input logic                                        frame_i,
  input logic [N_SUB*TAPS-2:0]                       tap_hist,
  input logic [fir_tree_pkg::lvl_off(N_SUB, $clog2(N_SUB)+1)-1:0] node_bits,
  input logic                                        y_o
);
  import fir_tree_pkg::*;

  localparam int LVL   = $clog2(N_SUB);
  localparam int FRAME = DATA_W + LVL;

  int   ck_pos_q;
  logic ck_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_pos_q <= 0;
      ck_run_q <= 1'b0;
    end else begin
      if (frame_i) begin
        ck_run_q <= 1'b1;
        ck_pos_q <= 1;
      end else begin
        ck_pos_q <= (ck_pos_q == FRAME - 1) ? 0 : ck_pos_q + 1;
      end
    end
  end

  // strobe cadence taken for granted by the checks below (R2)
  assert_frame_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_run_q |-> (frame_i == (ck_pos_q == 0)));

  assert_tap_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_run_q && !frame_i && ck_pos_q >= DATA_W) |=> $stable(tap_hist));

  assert_out_known_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(y_o));

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    for (genvar m = 0; m < lvl_cnt(N_SUB, l + 1); m++) begin : g_node
      localparam int SRC = lvl_off(N_SUB, l) + 2 * m;
      localparam int DST = lvl_off(N_SUB, l + 1) + m;
      if (2 * m + 1 < lvl_cnt(N_SUB, l)) begin : g_add
        assert_carry_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (ck_run_q && ck_pos_q == (l + 2) % FRAME) |->
            (node_bits[DST] == $past(node_bits[SRC] ^ node_bits[SRC+1])));
      end else begin : g_pass
        assert_pass_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ck_run_q |=> (node_bits[DST] == $past(node_bits[SRC])));
      end
    end
  end

endmodule

bind dist_fir_tree dist_fir_tree_chk #(
  .N_SUB  (N_SUB),
  .TAPS   (TAPS),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_i   (frame_i),
  .tap_hist  (tap_bits[N_SUB*TAPS-1:1]),
  .node_bits (nb),
  .y_o       (y_o)
);

// File: tb/sim_dist_fir_tree.sv
module sim_dist_fir_tree;
  localparam int CLK_PERIOD = 10;
  localparam int K    = 3;
  localparam int TAPS = 3;
  localparam int W    = 8;
  localparam int CW   = 6;
  localparam int LVL  = $clog2(K);
  localparam int F    = W + LVL;
  localparam int NC   = K * TAPS;
  localparam int NS   = 4 + 30 + 256 + 20 + 60;
  localparam int CF [NC] = '{5, -3, 11, -16, 7, 1, -9, 13, -32};

  function automatic logic [NC*CW-1:0] pack_coefs();
    logic [NC*CW-1:0] v;
    for (int g = 0; g < NC; g++) v[g*CW +: CW] = CW'(CF[g]);
    return v;
  endfunction

  localparam logic [NC*CW-1:0] COEFS = pack_coefs();

  logic clk_i = 1'b0, rst_ni = 1'b0, frame_i = 1'b0, x_i = 1'b0;
  logic y_o;

  dist_fir_tree #(
    .N_SUB (K), .TAPS (TAPS), .DATA_W (W), .COEF_W (CW), .COEFS (COEFS)
  ) u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .frame_i (frame_i), .x_i (x_i), .y_o (y_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int          n_chk = 0, n_fail = 0, p = 0;
  int          xs [NS];
  string       tg [NS];
  bit          ones [NS];
  logic [F-1:0] ycap [NS];
  logic [15:0] lfsr = 16'hace1;

  task automatic add_s(input int v, input string t, input bit o);
    xs[p] = v; tg[p] = t; ones[p] = o; p++;
  endtask

  task automatic check_sample(input int n);
    longint e;
    logic [F-1:0] eb;
    e = 0;
    for (int g = 0; g < NC; g++) if (n - g >= 0) e += longint'(CF[g]) * xs[n-g];
    eb = F'(e);
    n_chk++;
    if (ycap[n] !== eb) begin
      n_fail++;
      $display("FAIL %s sample %0d: actual %0h expected %0h", tg[n], n, ycap[n], eb);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    // R1: zero history after reset
    for (int i = 0; i < 4; i++) add_s(0, "R1", 1'b0);
    // R4 latency on the first result, R5 tap order, R9 on the unpaired group
    for (int o = 0; o < 10; o++)
      add_s(o == 0 ? 1 : 0, o == 0 ? "R4" : (o >= 6 && o <= 8) ? "R9" : "R5", 1'b0);
    // R6 extreme samples
    for (int o = 0; o < 10; o++) add_s(o == 0 ? -128 : 0, "R6", 1'b0);
    for (int o = 0; o < 10; o++) add_s(o == 0 ? 127 : 0, "R6", 1'b0);
    // R2 format and R3 value over every sample code
    for (int v = -128; v < 128; v++) add_s(v, (v < -112) ? "R2" : "R3", 1'b0);
    // R8 alternating extremes, no carry between results
    for (int i = 0; i < 20; i++) add_s((i % 2) ? 127 : -128, "R8", 1'b0);
    // R7 ones on x_i in spare cycles
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      add_s(int'($signed(lfsr[7:0])), "R7", 1'b1);
    end

    // R1: output held low during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      n_chk++;
      if (y_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 reset: actual %b expected 0", y_o);
      end
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < (NS + 2) * F + LVL + 2; k++) begin
      @(negedge clk_i);
      begin
        int m, n, j, n2, c, xv;
        logic [W-1:0] xb;
        m = k - 1 - LVL;
        if (m >= 0) begin
          n = m / F;
          j = m % F;
          if (n < NS) begin
            ycap[n][j] = y_o;
            if (j == F - 1) check_sample(n);
          end
        end
        n2 = k / F;
        c  = k % F;
        xv = (n2 < NS) ? xs[n2] : 0;
        xb = W'(xv);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        frame_i = (c == 0);
        if (c < W)                      x_i = xb[c];
        else if (n2 < NS && ones[n2])   x_i = 1'b1;
        else                            x_i = lfsr[0];
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule